// File: doc/BRIEF.md
# Multi-Channel PWM Controller with Synchronised Parameter Update

The block drives up to eight pulse-width-modulated channels (six by default) from one shared clock prescaler. Software programs each channel's period, compare threshold and dead time through a simple register write and read port. Each channel keeps these values in shadow registers and copies them to its working registers only when its period counter wraps. A per-channel hold mask can delay that copy, so several values, or several channels, change in the same period. Each channel drives a main output and a complementary output. A programmable dead time separates the two, so they are never high together.

One control write can switch a whole group of channels on or off. A direction bit selects whether the channels marked in the mask are turned on or turned off, and channels outside the mask keep their state. Each channel raises an event at every period wrap. The event latches in a pending register, which software clears by writing ones. The interrupt line is high while any pending bit is set.

The register port has no back-pressure. A write completes in the cycle its strobe is high, and read data is a combinational function of the read address. The PWM outputs and the interrupt line are plain level signals.

Top module: `pwm_bank`

## Requirements
- R1: The register map is:
  - 0x00 control: bit 0 core enable, bit 1 mask direction (write-only, reads 0), bits 12+i hold mask, bits 20+i channel enable.
  - 0x04 prescaler reload in bits 15:0.
  - 0x08 pending in bits i.
  - Channel i has period at 0x10+16i, compare at 0x14+16i and dead time at 0x18+16i (bits 7:0).
  - Unmapped addresses and unused bits read 0. After reset every register reads 0, except the reload, which reads 0xFFFF.
- R2: While core enable is 0, no tick occurs, every channel counter is held at 0, and both outputs of every channel are 0.
- R3: A control write with bit 1 = 0 sets the channel enables marked in bits 20+i. With bit 1 = 1 it clears them. Unmarked channels keep their enable.
- R4: While a channel's hold bit is 1 at its wrap, its working period, compare and dead time stay unchanged.
- R5: With core enable at 1, the prescaler counts down from the reload value. It emits a one-cycle tick when it reaches 0 and reloads, so a tick comes every reload+1 cycles. While disabled, it sits at the reload value.
- R6: An enabled channel's counter advances on each tick from 0 to its working period and then wraps to 0. The raw PWM level is high while the counter is below the working compare.
- R7: A wrap of an enabled channel sets its pending bit. Writing 1 to pending bit i clears it, but a set in the same cycle wins. The irq output is the OR of the pending bits.
- R8: The main output is high when the raw level, registered once, has been high for at least the dead-time count of cycles. The complementary output is the same for the low level. After any change of the raw level, both outputs are low for the dead-time count of cycles.
- R9: At a wrap with the hold bit at 0, the working values load from the shadow values. The working values reset to 0, so a newly enabled channel first wraps on its first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Any pending bit set |
| pwm_hi | output | NCH | Main output per channel |
| pwm_lo | output | NCH | Complementary output per channel |

## Verification
The assertions check the following on every cycle:
- the prescaler reload after a tick;
- that counters are idle when a channel is off and stay within the working period;
- that working values are frozen outside an unheld wrap and loaded at one;
- that a pending bit is set after a wrap and cleared by an uncontested write;
- the effect of group enable and disable writes;
- the low gap on both outputs after each raw transition.

Other behaviours can only be shown by the bench's scenarios, which a cycle-level reference model follows:
- the exact output waveforms for several period, compare and dead-time settings;
- the moment held values take effect once the hold is released;
- the set-wins collision with a clear written every cycle;
- the full readback map.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned OFS_CTRL      = 32'h00;
  localparam int unsigned OFS_SCALE     = 32'h04;
  localparam int unsigned OFS_PEND      = 32'h08;
  localparam int unsigned CH_BASE       = 32'h10;
  localparam int unsigned CH_STRIDE     = 32'h10;
  localparam int unsigned CH_OFS_PER    = 32'h0;
  localparam int unsigned CH_OFS_CMP    = 32'h4;
  localparam int unsigned CH_OFS_DEAD   = 32'h8;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_DIR_BIT  = 1;
  localparam int unsigned CTRL_HOLD_LSB = 12;
  localparam int unsigned CTRL_CHEN_LSB = 20;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [PSW-1:0] reload,
  output logic           tick
);
  logic [PSW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '1;
    else if (!en || cnt_q == '0) cnt_q <= reload;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  assign tick = en && (cnt_q == '0);

  // R5: after a tick the count restarts from the reload value
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(reload)));
  // R2: no ticks come while the core is off
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           on,
  input  logic           raw,
  input  logic [DBW-1:0] dead,
  output logic           hi,
  output logic           lo
);
  logic           raw_q;
  logic [DBW-1:0] age_q;
  logic           settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      age_q <= '0;
    end else if (raw != raw_q) begin
      raw_q <= raw;
      age_q <= '0;
    end else if (age_q < dead) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign settled = (age_q >= dead);
  assign hi      = on && raw_q && settled;
  assign lo      = on && !raw_q && settled;

  // R8: a raw transition opens a gap on both outputs when dead time is non-zero
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw != raw_q) ##1 (dead != '0) |-> (!hi && !lo));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW  = 16,
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           on,
  input  logic           tick,
  input  logic           hold,
  input  logic           wr_per,
  input  logic           wr_cmp,
  input  logic           wr_dead,
  input  logic [31:0]    wdata,
  output logic [CW-1:0]  sh_per,
  output logic [CW-1:0]  sh_cmp,
  output logic [DBW-1:0] sh_dead,
  output logic           wrap,
  output logic           hi,
  output logic           lo
);
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  per_a;
  logic [CW-1:0]  cmp_a;
  logic [DBW-1:0] dead_a;
  logic           raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per  <= '0;
      sh_cmp  <= '0;
      sh_dead <= '0;
    end else begin
      if (wr_per)  sh_per  <= wdata[CW-1:0];
      if (wr_cmp)  sh_cmp  <= wdata[CW-1:0];
      if (wr_dead) sh_dead <= wdata[DBW-1:0];
    end
  end

  assign wrap = on && tick && (cnt_q == per_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!on)  cnt_q <= '0;
    else if (tick) cnt_q <= (cnt_q == per_a) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_a  <= '0;
      cmp_a  <= '0;
      dead_a <= '0;
    end else if (wrap && !hold) begin
      per_a  <= sh_per;
      cmp_a  <= sh_cmp;
      dead_a <= sh_dead;
    end
  end

  assign raw = on && (cnt_q < cmp_a);

  pwm_deadband #(.DBW(DBW)) u_db (
    .clk  (clk),
    .rst_n(rst_n),
    .on   (on),
    .raw  (raw),
    .dead (dead_a),
    .hi   (hi),
    .lo   (lo)
  );

  // R2: an idle channel keeps its counter at zero
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (cnt_q == '0));
  // R6: the counter never passes the working period
  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_a);
  // R4: working values move only at an unheld wrap
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap && !hold) |=> ($stable(per_a) && $stable(cmp_a) && $stable(dead_a)));
  // R9: an unheld wrap loads the shadow values
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !hold) |=> (per_a == $past(sh_per) && cmp_a == $past(sh_cmp)
                         && dead_a == $past(sh_dead)));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int DBW = 8,
  parameter int PSW = 16,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [31:0]    rd_data,
  output logic           irq,
  output logic [NCH-1:0] pwm_hi,
  output logic [NCH-1:0] pwm_lo
);
  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_SCALE = AW'(OFS_SCALE);
  localparam logic [AW-1:0] A_PEND  = AW'(OFS_PEND);

  logic                  core_en;
  logic [NCH-1:0]        ch_en;
  logic [NCH-1:0]        hold;
  logic [PSW-1:0]        reload;
  logic [NCH-1:0]        pend;
  logic [NCH-1:0]        wrap_v;
  logic [NCH-1:0]        clr_v;
  logic [NCH-1:0]        wmask;
  logic                  tick;
  logic                  ctrl_wr;
  logic [NCH-1:0][CW-1:0]  rb_per;
  logic [NCH-1:0][CW-1:0]  rb_cmp;
  logic [NCH-1:0][DBW-1:0] rb_dead;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign wmask   = wr_data[CTRL_CHEN_LSB +: NCH];
  assign clr_v   = (wr_en && wr_addr == A_PEND) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en <= 1'b0;
      ch_en   <= '0;
      hold    <= '0;
      reload  <= '1;
    end else begin
      if (ctrl_wr) begin
        core_en <= wr_data[CTRL_EN_BIT];
        hold    <= wr_data[CTRL_HOLD_LSB +: NCH];
        if (wr_data[CTRL_DIR_BIT]) ch_en <= ch_en & ~wmask;
        else                       ch_en <= ch_en | wmask;
      end
      if (wr_en && wr_addr == A_SCALE) reload <= wr_data[PSW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_v) | wrap_v;
  end

  assign irq = |pend;

  pwm_prescaler #(.PSW(PSW)) u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (core_en),
    .reload(reload),
    .tick  (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_PER  = AW'(CH_BASE + CH_STRIDE*i + CH_OFS_PER);
    localparam logic [AW-1:0] A_CMP  = AW'(CH_BASE + CH_STRIDE*i + CH_OFS_CMP);
    localparam logic [AW-1:0] A_DEAD = AW'(CH_BASE + CH_STRIDE*i + CH_OFS_DEAD);

    pwm_channel #(.CW(CW), .DBW(DBW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .on     (core_en && ch_en[i]),
      .tick   (tick),
      .hold   (hold[i]),
      .wr_per (wr_en && wr_addr == A_PER),
      .wr_cmp (wr_en && wr_addr == A_CMP),
      .wr_dead(wr_en && wr_addr == A_DEAD),
      .wdata  (wr_data),
      .sh_per (rb_per[i]),
      .sh_cmp (rb_cmp[i]),
      .sh_dead(rb_dead[i]),
      .wrap   (wrap_v[i]),
      .hi     (pwm_hi[i]),
      .lo     (pwm_lo[i])
    );

    // R7: a wrap always leaves its pending bit set, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[i] |=> pend[i]);
    // R7: an uncontested clear empties the bit
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !wrap_v[i]) |=> !pend[i]);
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) begin
      rd_data[CTRL_EN_BIT]            = core_en;
      rd_data[CTRL_HOLD_LSB +: NCH]   = hold;
      rd_data[CTRL_CHEN_LSB +: NCH]   = ch_en;
    end else if (rd_addr == A_SCALE) begin
      rd_data[PSW-1:0] = reload;
    end else if (rd_addr == A_PEND) begin
      rd_data[NCH-1:0] = pend;
    end
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(CH_BASE + CH_STRIDE*i + CH_OFS_PER))  rd_data[CW-1:0]  = rb_per[i];
      if (rd_addr == AW'(CH_BASE + CH_STRIDE*i + CH_OFS_CMP))  rd_data[CW-1:0]  = rb_cmp[i];
      if (rd_addr == AW'(CH_BASE + CH_STRIDE*i + CH_OFS_DEAD)) rd_data[DBW-1:0] = rb_dead[i];
    end
  end

  // R3: group enable sets every marked channel
  p_group_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[CTRL_DIR_BIT]) |=>
      ((ch_en & $past(wmask)) == $past(wmask)));
  // R3: group disable clears every marked channel
  p_group_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data[CTRL_DIR_BIT]) |=> ((ch_en & $past(wmask)) == '0));
  // R2: outputs are quiet while the core is off
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (pwm_hi == '0 && pwm_lo == '0));
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic [NCH-1:0] pwm_hi, pwm_lo;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string phase = "R1";

  pwm_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int m_en, m_reload, m_ps, m_pend;
  int m_chen[NCH], m_hold[NCH];
  int s_per[NCH], s_cmp[NCH], s_db[NCH];
  int a_per[NCH], a_cmp[NCH], a_db[NCH];
  int m_cnt[NCH], m_rq[NCH], m_age[NCH];

  task automatic m_reset();
    m_en = 0; m_reload = 'hFFFF; m_ps = 'hFFFF; m_pend = 0;
    for (int i = 0; i < NCH; i++) begin
      m_chen[i] = 0; m_hold[i] = 0; s_per[i] = 0; s_cmp[i] = 0; s_db[i] = 0;
      a_per[i] = 0; a_cmp[i] = 0; a_db[i] = 0; m_cnt[i] = 0; m_rq[i] = 0; m_age[i] = 0;
    end
  endtask

  function automatic int m_on(int i);
    return (m_en != 0 && m_chen[i] != 0) ? 1 : 0;
  endfunction

  function automatic int m_hi(int i);
    return (m_on(i) != 0 && m_rq[i] != 0 && m_age[i] >= a_db[i]) ? 1 : 0;
  endfunction

  function automatic int m_lo(int i);
    return (m_on(i) != 0 && m_rq[i] == 0 && m_age[i] >= a_db[i]) ? 1 : 0;
  endfunction

  function automatic int m_rd(int a);
    int v = 0;
    if (a == 0) begin
      v = m_en;
      for (int i = 0; i < NCH; i++) v = v | (m_hold[i] << (12 + i)) | (m_chen[i] << (20 + i));
    end else if (a == 4) v = m_reload;
    else if (a == 8) v = m_pend;
    for (int i = 0; i < NCH; i++) begin
      if (a == 16 + 16*i) v = s_per[i];
      if (a == 20 + 16*i) v = s_cmp[i];
      if (a == 24 + 16*i) v = s_db[i];
    end
    return v;
  endfunction

  task automatic m_step();
    int tick, w, a, d;
    int raw[NCH];
    tick = (m_en != 0 && m_ps == 0) ? 1 : 0;
    for (int i = 0; i < NCH; i++)
      raw[i] = (m_on(i) != 0 && m_cnt[i] < a_cmp[i]) ? 1 : 0;
    // dead-band ageing uses the working dead time of this cycle
    for (int i = 0; i < NCH; i++) begin
      if (raw[i] != m_rq[i]) begin m_rq[i] = raw[i]; m_age[i] = 0; end
      else if (m_age[i] < a_db[i]) m_age[i]++;
    end
    w = 0;
    for (int i = 0; i < NCH; i++) begin
      if (m_on(i) == 0) m_cnt[i] = 0;
      else if (tick != 0) begin
        if (m_cnt[i] == a_per[i]) begin
          m_cnt[i] = 0;
          w = w | (1 << i);
          if (m_hold[i] == 0) begin a_per[i] = s_per[i]; a_cmp[i] = s_cmp[i]; a_db[i] = s_db[i]; end
        end else m_cnt[i]++;
      end
    end
    a = int'(wr_addr); d = int'(wr_data);
    if (wr_en && a == 8) m_pend = (m_pend & ~(d & 'h3F)) | w;
    else                 m_pend = m_pend | w;
    if (m_en == 0 || m_ps == 0) m_ps = m_reload; else m_ps--;
    if (wr_en) begin
      if (a == 0) begin
        m_en = d & 1;
        for (int i = 0; i < NCH; i++) begin
          m_hold[i] = (d >> (12 + i)) & 1;
          if (((d >> (20 + i)) & 1) != 0) m_chen[i] = ((d >> 1) & 1) != 0 ? 0 : 1;
        end
      end
      if (a == 4) m_reload = d & 'hFFFF;
      for (int i = 0; i < NCH; i++) begin
        if (a == 16 + 16*i) s_per[i] = d & 'hFFFF;
        if (a == 20 + 16*i) s_cmp[i] = d & 'hFFFF;
        if (a == 24 + 16*i) s_db[i]  = d & 'hFF;
      end
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", phase, what, act, exp, cyc);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk($sformatf("rd_data@%0h", rd_addr), int'(rd_data), m_rd(int'(rd_addr)));
      chk("irq", int'(irq), (m_pend != 0) ? 1 : 0);
      for (int i = 0; i < NCH; i++) begin
        chk($sformatf("pwm_hi[%0d]", i), int'(pwm_hi[i]), m_hi(i));
        chk($sformatf("pwm_lo[%0d]", i), int'(pwm_lo[i]), m_lo(i));
        if (m_en == 0) chk($sformatf("R2 quiet[%0d]", i), int'(pwm_hi[i] | pwm_lo[i]), 0);
      end
      rd_addr <= rd_addr + 8'd4;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";                       // reset readback of the whole map
    idle(70);
    phase = "R6";                       // channel timing with several shapes
    wr(4, 1);
    wr(16, 4);  wr(20, 2);  wr(24, 1);  // ch0
    wr(32, 3);  wr(36, 0);  wr(40, 0);  // ch1 never high
    wr(48, 5);  wr(52, 9);  wr(56, 2);  // ch2 always high
    wr(64, 2);  wr(68, 1);  wr(72, 0);  // ch3
    wr(0, 32'h00F0_0001);
    idle(200);
    phase = "R8";                       // wider dead time on ch0
    wr(16, 9); wr(20, 5); wr(24, 3);
    idle(200);
    phase = "R3";                       // group disable then group enable
    wr(0, 32'h0050_0003);
    idle(60);
    wr(80, 1); wr(84, 1); wr(88, 1);
    wr(96, 6); wr(100, 3); wr(104, 0);
    wr(0, 32'h0330_0001);
    idle(120);
    phase = "R4";                       // hold ch1 and ch3 while changing them
    wr(0, 32'h0000_A001);
    wr(32, 7); wr(36, 4); wr(40, 1);
    wr(64, 5); wr(68, 2); wr(72, 2);
    idle(150);
    phase = "R9";                       // release: both load at their next wrap
    wr(0, 32'h0000_0001);
    idle(150);
    phase = "R5";                       // prescaler changes
    wr(4, 0);
    idle(80);
    wr(4, 4);
    idle(150);
    phase = "R7";                       // clear written while wraps land
    wr(4, 0);
    wr(96, 0);
    idle(20);
    for (int k = 0; k < 40; k++) wr(8, 32'h3F);
    wr(0, 32'h03F0_0003);
    idle(5);
    wr(8, 32'h3F);
    idle(10);
    phase = "R2";                       // core off, then back on
    wr(0, 32'h03F0_0001);
    idle(30);
    wr(0, 32'h0000_0000);
    idle(60);
    wr(0, 32'h0000_0001);
    idle(80);
    phase = "R1";                       // all-ones control write, reserved bits
    wr(0, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_0003);
    wr(24, 32'h0000_FF07);
    idle(70);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule